// File: doc/BRIEF.md
# Address-Space Chip-Select Decoder

This block turns a 16-bit processor address, qualified by an active-low address-valid strobe, into one active-low select line per device on an 8-bit system. The five devices are an 8 KB program store, a 512-byte peripheral window, a 4-byte keypad, a 4 KB variable RAM and a 4 KB serial-buffer RAM. Each device also receives the low-order offset bits it needs.

A module parameter picks the decode style. Full decode compares every address line that is not a device offset bit, so each location answers at exactly one address. Partial decode compares only a few high lines. It needs less logic, but every device then repeats across large parts of the space. An unmapped flag marks a qualified address that selects nothing.

The decode is combinational. A registered copy of the selects and of the flag is also provided, one clock later, so a checker can sample it at a fixed time.

Top module: `mmap_csel`

## Requirements
- R1: With full decode and the strobe low, `cs_n_o[0]` (program store) is low exactly for addresses 0x0000–0x1FFF.
- R2: With full decode and the strobe low, `cs_n_o[1]` (peripheral window) is low exactly for addresses 0x4000–0x41FF.
- R3: With full decode and the strobe low, `cs_n_o[2]` (keypad) is low exactly for addresses 0x9000–0x9003.
- R4: With full decode and the strobe low, `cs_n_o[3]` (variable RAM) is low exactly for 0xC000–0xCFFF, and `cs_n_o[4]` (serial-buffer RAM) is low exactly for 0xD000–0xDFFF.
- R5: While `addr_valid_n_i` is high, all selects are high and `unmapped_o` is low, whatever the address.
- R6: At most one bit of `cs_n_o` is low at any time.
- R7: With full decode and the strobe low, the addresses in 0x2000–0x3FFF, 0x4200–0x8FFF, 0x9004–0xBFFF and 0xE000–0xFFFF drive no select, and `unmapped_o` is high.
- R8: `offset_o` carries the address masked to the selected device's offset bits. That is 13 bits for the program store, 9 for the peripheral window, 2 for the keypad and 12 for either RAM. It is zero when no select is low.
- R9: With partial decode and the strobe low, bits A15:A14 choose the device: 00 selects the program store, 01 the peripheral window and 10 the keypad. For 11, bit A12 chooses between the variable RAM (0) and the serial-buffer RAM (1). `unmapped_o` stays low.
- R10: `cs_n_q_o` and `unmapped_q_o` equal the values `cs_n_o` and `unmapped_o` had at the previous rising clock edge. While reset is high, the rising edge loads all ones into `cs_n_q_o` and zero into `unmapped_q_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the registered copy |
| rst_i | input | 1 | Synchronous reset, active high |
| addr_i | input | 16 | Processor address |
| addr_valid_n_i | input | 1 | Address-valid strobe, active low |
| cs_n_o | output | 5 | Active-low selects: 0 store, 1 peripherals, 2 keypad, 3 variable RAM, 4 serial RAM |
| unmapped_o | output | 1 | Qualified address selects no device |
| offset_o | output | 13 | Offset bits for the selected device |
| cs_n_q_o | output | 5 | Registered copy of `cs_n_o` |
| unmapped_q_o | output | 1 | Registered copy of `unmapped_o` |

## Verification
The bench builds two instances side by side, one with `FULL_DECODE` set to 1 and one with it set to 0, and drives both with the same address and strobe. The full instance exposes the exact region edges, the four gaps and the unmapped flag. The partial instance exposes the aliasing: a device answers at addresses far from its nominal base, and the flag never rises. Offset masking is checked on both instances, because it depends only on which device is selected.

// File: rtl/mmap_csel_pkg.sv
package mmap_csel_pkg;
    localparam int ADDR_W = 16;
    localparam int NDEV   = 5;
    localparam int OFS_W  = 13;

    typedef enum logic [2:0] {
        DEV_STORE  = 3'd0,
        DEV_PERIPH = 3'd1,
        DEV_KEYPAD = 3'd2,
        DEV_VARRAM = 3'd3,
        DEV_SERRAM = 3'd4
    } dev_e;

    typedef struct packed {
        logic [NDEV-1:0] cs_n;
        logic            unmapped;
    } sel_t;

    // Base address compared against the cared-for lines.
    function automatic logic [ADDR_W-1:0] dev_base(input int d, input bit full);
        case (d)
            0:       return 16'h0000;
            1:       return 16'h4000;
            2:       return full ? 16'h9000 : 16'h8000;
            3:       return 16'hC000;
            default: return 16'hD000;
        endcase
    endfunction

    // Lines that take part in the comparison for each device.
    function automatic logic [ADDR_W-1:0] dev_care(input int d, input bit full);
        case (d)
            0:       return full ? 16'hE000 : 16'hC000;
            1:       return full ? 16'hFE00 : 16'hC000;
            2:       return full ? 16'hFFFC : 16'hC000;
            3:       return full ? 16'hF000 : 16'hD000;
            default: return full ? 16'hF000 : 16'hD000;
        endcase
    endfunction

    // Offset bits handed to each device.
    function automatic logic [OFS_W-1:0] dev_ofs_mask(input int d);
        case (d)
            0:       return 13'h1FFF;
            1:       return 13'h01FF;
            2:       return 13'h0003;
            default: return 13'h0FFF;
        endcase
    endfunction
endpackage

// File: rtl/mmap_csel_match.sv
module mmap_csel_match #(
    parameter logic [15:0] CARE = 16'hFFFF,
    parameter logic [15:0] BASE = 16'h0000
) (
    input  logic [15:0] addr_i,
    output logic        hit_o
);
    always_comb hit_o = ((addr_i & CARE) == (BASE & CARE));
endmodule

// File: rtl/mmap_csel_reg.sv
module mmap_csel_reg
    import mmap_csel_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  sel_t d_i,
    output sel_t q_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            q_o.cs_n     <= '1;
            q_o.unmapped <= 1'b0;
        end else begin
            q_o <= d_i;
        end
    end

    assert_copy_follows_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(!rst_i) |-> (q_o == $past(d_i)));
endmodule

// File: rtl/mmap_csel.sv
module mmap_csel
    import mmap_csel_pkg::*;
#(
    parameter bit FULL_DECODE = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              addr_valid_n_i,
    output logic [NDEV-1:0]   cs_n_o,
    output logic              unmapped_o,
    output logic [OFS_W-1:0]  offset_o,
    output logic [NDEV-1:0]   cs_n_q_o,
    output logic              unmapped_q_o
);
    logic [NDEV-1:0] hit;
    logic [NDEV-1:0] sel;
    sel_t            cur, held;

    for (genvar d = 0; d < NDEV; d++) begin : g_dev
        mmap_csel_match #(
            .CARE(dev_care(d, FULL_DECODE)),
            .BASE(dev_base(d, FULL_DECODE))
        ) match_i (
            .addr_i(addr_i),
            .hit_o (hit[d])
        );
    end

    always_comb begin
        sel      = addr_valid_n_i ? '0 : hit;
        offset_o = '0;
        for (int d = 0; d < NDEV; d++) begin
            if (sel[d]) offset_o = addr_i[OFS_W-1:0] & dev_ofs_mask(d);
        end
    end

    assign cs_n_o       = ~sel;
    assign unmapped_o   = !addr_valid_n_i && (sel == '0);
    assign cur.cs_n     = cs_n_o;
    assign cur.unmapped = unmapped_o;

    mmap_csel_reg reg_i (
        .clk_i(clk_i),
        .rst_i(rst_i),
        .d_i  (cur),
        .q_o  (held)
    );

    assign cs_n_q_o     = held.cs_n;
    assign unmapped_q_o = held.unmapped;

    assert_idle_strobe_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        addr_valid_n_i |-> (cs_n_o == '1 && !unmapped_o));
    assert_single_select_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(~cs_n_o));
    assert_flag_excl_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        unmapped_o |-> (cs_n_o == '1));
    assert_offset_zero_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (cs_n_o == '1) |-> (offset_o == '0));
    assert_partial_covers_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (!FULL_DECODE && !addr_valid_n_i) |-> (!unmapped_o && $countones(~cs_n_o) == 1));
endmodule

// File: tb/mmap_csel_tb_top.sv
module mmap_csel_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] addr = '0;
    logic        vld_n = 1'b1;

    logic [4:0]  f_cs, p_cs, f_csq, p_csq;
    logic        f_un, p_un, f_unq, p_unq;
    logic [12:0] f_ofs, p_ofs;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [11:0] exp_q[$];

    always #4 clk = ~clk;

    mmap_csel #(.FULL_DECODE(1'b1)) dut_i (
        .clk_i(clk), .rst_i(rst), .addr_i(addr), .addr_valid_n_i(vld_n),
        .cs_n_o(f_cs), .unmapped_o(f_un), .offset_o(f_ofs),
        .cs_n_q_o(f_csq), .unmapped_q_o(f_unq));

    mmap_csel #(.FULL_DECODE(1'b0)) dut_p_i (
        .clk_i(clk), .rst_i(rst), .addr_i(addr), .addr_valid_n_i(vld_n),
        .cs_n_o(p_cs), .unmapped_o(p_un), .offset_o(p_ofs),
        .cs_n_q_o(p_csq), .unmapped_q_o(p_unq));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%h act=%h exp=%h", req, addr, act, exp);
        end
    endtask

    function automatic int full_dev(input logic [15:0] a);
        if (a <= 16'h1FFF) return 0;
        if (a >= 16'h4000 && a <= 16'h41FF) return 1;
        if (a >= 16'h9000 && a <= 16'h9003) return 2;
        if (a >= 16'hC000 && a <= 16'hCFFF) return 3;
        if (a >= 16'hD000 && a <= 16'hDFFF) return 4;
        return -1;
    endfunction

    function automatic int part_dev(input logic [15:0] a);
        if (a[15:14] != 2'b11) return int'(a[15:14]);
        return a[12] ? 4 : 3;
    endfunction

    function automatic logic [12:0] ofs_of(input int d, input logic [15:0] a);
        case (d)
            0: return a[12:0];
            1: return {4'd0, a[8:0]};
            2: return {11'd0, a[1:0]};
            3, 4: return {1'b0, a[11:0]};
            default: return 13'd0;
        endcase
    endfunction

    // Driver: applies one address, checks the combinational outputs, queues the registered expectation.
    task automatic drive(input logic [15:0] a, input logic v_n);
        int fd, pd;
        logic [4:0] fe, pe;
        logic fu, pu;
        @(negedge clk);
        addr  = a;
        vld_n = v_n;
        #1;
        fd = v_n ? -1 : full_dev(a);
        pd = v_n ? -1 : part_dev(a);
        fe = 5'h1F; pe = 5'h1F;
        if (fd >= 0) fe[fd] = 1'b0;
        if (pd >= 0) pe[pd] = 1'b0;
        fu = !v_n && fd < 0;
        pu = 1'b0;
        if (v_n) begin
            check("R5 full cs", {27'd0, f_cs}, 32'h1F);
            check("R5 partial cs", {27'd0, p_cs}, 32'h1F);
            check("R5 flag", {30'd0, f_un, p_un}, 32'd0);
        end else begin
            case (fd)
                0: check("R1 store select", {27'd0, f_cs}, {27'd0, fe});
                1: check("R2 periph select", {27'd0, f_cs}, {27'd0, fe});
                2: check("R3 keypad select", {27'd0, f_cs}, {27'd0, fe});
                3, 4: check("R4 ram select", {27'd0, f_cs}, {27'd0, fe});
                default: check("R7 gap no select", {27'd0, f_cs}, {27'd0, fe});
            endcase
            check("R7 full unmapped flag", {31'd0, f_un}, {31'd0, fu});
            check("R9 partial select", {27'd0, p_cs}, {27'd0, pe});
            check("R9 partial flag", {31'd0, p_un}, 32'd0);
        end
        check("R6 one-hot full", {31'd0, $countones(~f_cs) <= 1}, 32'd1);
        check("R8 full offset", {19'd0, f_ofs}, {19'd0, ofs_of(fd, a)});
        check("R8 partial offset", {19'd0, p_ofs}, {19'd0, ofs_of(pd, a)});
        exp_q.push_back({fe, fu, pe, pu});
    endtask

    // Monitor: after each edge, compares the registered copies with the oldest queued expectation.
    always @(posedge clk) begin
        #2;
        if (!rst && exp_q.size() > 0) begin
            logic [11:0] e;
            e = exp_q.pop_front();
            check("R10 registered copy", {20'd0, f_csq, f_unq, p_csq, p_unq}, {20'd0, e});
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset state", {20'd0, f_csq, f_unq, p_csq, p_unq}, {20'd0, 5'h1F, 1'b0, 5'h1F, 1'b0});
        rst = 1'b0;
        foreach (edges[i]) drive(edges[i], 1'b0);
        drive(16'h0000, 1'b1);
        drive(16'hC123, 1'b1);
        drive(16'h9002, 1'b1);
        for (int i = 0; i < 400; i++) begin
            logic [15:0] a;
            a = 16'($urandom);
            drive(a, (i % 9) == 4);
        end
        drive(16'h9001, 1'b0);
        repeat (3) @(negedge clk);
        done = 1'b1;
    end

    logic [15:0] edges[26] = '{
        16'h0000, 16'h1FFF, 16'h2000, 16'h3FFF, 16'h4000, 16'h41FF, 16'h4200,
        16'h8FFF, 16'h9000, 16'h9003, 16'h9004, 16'hBFFF, 16'hC000, 16'hCFFF,
        16'hD000, 16'hDFFF, 16'hE000, 16'hFFFF, 16'h7ABC, 16'h8001, 16'hEABC,
        16'hF123, 16'h5E07, 16'h9102, 16'h2345, 16'hB00F};

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog act=timeout exp=completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule